// File: doc/BRIEF.md
# Compact Instruction Register ALU

This block is the two-operand arithmetic and logic unit for the register-to-register group of a 16-bit compressed instruction set. It is purely combinational. It receives a 4-bit operation code, a destination operand (which is also the first source), a second source operand and the current N, Z, C and V condition flags. It returns the result, a strobe saying whether the result should be written back to the destination, and the next value of all four flags.

The sixteen operations fall into four groups. The first is bitwise logic: AND, EOR, ORR, BIC, MVN and TST. The second is shifts by a register amount: LSL, LSR, ASR and ROR. The third is add and subtract: ADC, SBC, NEG, CMP and CMN. The last is a truncating MUL. The three test and compare codes update the flags but suppress the write strobe. Register file access, decode and exception handling belong to the surrounding pipeline.

Top module: `cisa_reg_alu`

## Requirements
- R1: The opcode values are 0 AND, 1 EOR, 2 LSL, 3 LSR, 4 ASR, 5 ADC, 6 SBC, 7 ROR, 8 TST, 9 NEG, 10 CMP, 11 CMN, 12 ORR, 13 MUL, 14 BIC, 15 MVN. `wr_en_o` is 1 for every code except 8, 10 and 11.
- R2: The logic codes give AND, XOR and OR of the operands. BIC gives dest AND NOT src, MVN gives NOT src, and TST forms dest AND src for the flags only. These codes keep C and V at their input values.
- R3: Subtraction is dest + ~src + carry-in. ADC and SBC take the incoming C as carry-in. For all adds and subtracts, C is the carry out of bit 31 and V is signed overflow.
- R4: NEG computes 0 + ~src + 1. This gives C=1 and result 0 when src is 0, and V=1 when src is 0x8000_0000.
- R5: CMP is a subtract with carry-in 1 and CMN is an add with carry-in 0. Both set all four flags and hold `wr_en_o` low.
- R6: LSL shifts dest left by the amount. C is the last bit shifted out. An amount of exactly 32 gives result 0 with C = dest bit 0. An amount above 32 gives result 0 with C = 0.
- R7: LSR shifts dest right with zero fill. C is the last bit shifted out. An amount of exactly 32 gives result 0 with C = dest bit 31. An amount above 32 gives result 0 with C = 0.
- R8: ASR shifts dest right with sign fill. An amount of 32 or more gives every bit equal to dest bit 31, and C equal to that bit as well.
- R9: ROR rotates dest right by the amount modulo 32. When the amount is non-zero, C equals bit 31 of the result, including when the amount is a multiple of 32.
- R10: The shift amount is src bits 7:0 and src bits 31:8 have no effect. An amount of 0 returns dest unchanged and keeps the incoming C.
- R11: MUL returns the low 32 bits of dest × src and keeps C and V at their input values.
- R12: For every code, N is bit 31 of the computed value and Z is 1 exactly when the computed value is zero. Logic, shift and multiply codes keep V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (R1 encoding) |
| dst_i | input | 32 | Destination operand, also the value shifted |
| src_i | input | 32 | Second operand, also the shift amount source |
| n_i | input | 1 | Incoming negative flag |
| z_i | input | 1 | Incoming zero flag |
| c_i | input | 1 | Incoming carry flag |
| v_i | input | 1 | Incoming overflow flag |
| result_o | output | 32 | Computed value |
| wr_en_o | output | 1 | Result should be written to the destination |
| n_o | output | 1 | Next negative flag |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| v_o | output | 1 | Next overflow flag |

## Verification
The bench concentrates on the shift amount boundaries: 0, 1, 31, 32, 33, a multiple of 32 for ROR, and values whose upper source bits are non-zero. A shifter that masked the amount to five bits would return dest unchanged where zero is expected, and a shifter that used all 32 bits of the source would zero out a small shift. The bench also drives NEG of zero and of the most negative value, SBC with a clear carry, and overflow on ADC, where a misplaced carry-in or inversion shows up as a result off by one or a wrong C or V. Compares and TST are run with data that would corrupt a register if the write strobe leaked. A randomized sweep over all sixteen codes is checked against an independent bit-serial model.

// File: rtl/cisa_alu_pkg.sv
package cisa_alu_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_LSL = 4'd2,  OP_LSR = 4'd3,
      OP_ASR = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_ROR = 4'd7,
      OP_TST = 4'd8,  OP_NEG = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
      OP_ORR = 4'd12, OP_MUL = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
   } alu_op_e;

   typedef enum logic [1:0] {
      SH_LSL = 2'd0,
      SH_LSR = 2'd1,
      SH_ASR = 2'd2,
      SH_ROR = 2'd3
   } shift_kind_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } alu_flags_t;

endpackage

// File: rtl/cisa_alu_logic.sv
module cisa_alu_logic
   import cisa_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);

   always_comb begin
      unique case (op)
         OP_AND, OP_TST: y = a & b;
         OP_EOR:         y = a ^ b;
         OP_ORR:         y = a | b;
         OP_BIC:         y = a & ~b;
         OP_MVN:         y = ~b;
         default:        y = '0;
      endcase
   end

   always_comb begin
      if (op == OP_MVN)
         AST_MVN_IGNORES_DEST: assert (y == ~b); // R2
   end

endmodule

// File: rtl/cisa_alu_shifter.sv
module cisa_alu_shifter
   import cisa_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8
) (
   input  shift_kind_e       kind,
   input  logic [DATA_W-1:0] val,
   input  logic [AMT_W-1:0]  amt,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output logic              c_out
);

   localparam int LOG2W = $clog2(DATA_W);

   logic [DATA_W:0]          lsl_w;
   logic [DATA_W:0]          lsr_w;
   logic signed [DATA_W:0]   asr_w;
   logic [LOG2W-1:0]         rot;
   logic [LOG2W:0]           rot_back;
   logic [DATA_W-1:0]        ror_v;

   always_comb begin
      // one extra bit beside the data catches the last bit shifted out
      lsl_w    = {1'b0, val} << amt;
      lsr_w    = {val, 1'b0} >> amt;
      asr_w    = $signed({val, 1'b0}) >>> amt;
      rot      = amt[LOG2W-1:0];
      rot_back = (LOG2W+1)'(DATA_W) - {1'b0, rot};
      ror_v    = (val >> rot) | (val << rot_back);

      if (amt == '0) begin
         res   = val;
         c_out = c_in;
      end else begin
         unique case (kind)
            SH_LSL: begin res = lsl_w[DATA_W-1:0]; c_out = lsl_w[DATA_W]; end
            SH_LSR: begin res = lsr_w[DATA_W:1];   c_out = lsr_w[0];      end
            SH_ASR: begin res = asr_w[DATA_W:1];   c_out = asr_w[0];      end
            default: begin res = ror_v;            c_out = ror_v[DATA_W-1]; end
         endcase
      end
   end

   always_comb begin
      if (kind == SH_LSL && amt > AMT_W'(DATA_W))
         AST_LSL_WIDE_CLEARS: assert (res == '0 && !c_out); // R6
      if (kind == SH_ASR && amt >= AMT_W'(DATA_W))
         AST_ASR_SIGN_FILL: assert (res == {DATA_W{val[DATA_W-1]}} && c_out == val[DATA_W-1]); // R8
      if (kind == SH_ROR && amt != '0 && rot == '0)
         AST_ROR_FULL_TURN: assert (res == val && c_out == val[DATA_W-1]); // R9
   end

endmodule

// File: rtl/cisa_alu_addsub.sv
module cisa_alu_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              c_out,
   output logic              v_out
);

   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   wide;

   always_comb begin
      b_eff = sub ? ~b : b;
      wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
      sum   = wide[DATA_W-1:0];
      c_out = wide[DATA_W];
      v_out = (a[DATA_W-1] == b_eff[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
   end

   always_comb begin
      if (sub && cin && a == b)
         AST_SUB_SELF_ZERO: assert (sum == '0 && c_out && !v_out); // R3
   end

endmodule

// File: rtl/cisa_alu_mul.sv
module cisa_alu_mul #(
   parameter int DATA_W    = 32,
   parameter int MUL_STYLE = 0   // 0: inferred operator, 1: shift-add array
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] p
);

   generate
      if (MUL_STYLE == 0) begin : g_infer
         assign p = a * b;
      end else begin : g_array
         logic [DATA_W-1:0] pp [DATA_W];
         for (genvar i = 0; i < DATA_W; i++) begin : g_pp
            assign pp[i] = b[i] ? (a << i) : '0;
         end
         always_comb begin
            p = '0;
            for (int k = 0; k < DATA_W; k++) p = p + pp[k];
         end
      end
   endgenerate

   always_comb begin
      if (a == '0 || b == '0)
         AST_MUL_ZERO_FACTOR: assert (p == '0); // R11
   end

endmodule

// File: rtl/cisa_reg_alu.sv
module cisa_reg_alu
   import cisa_alu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int AMT_W     = 8,
   parameter int MUL_STYLE = 0
) (
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic              n_i,
   input  logic              z_i,
   input  logic              c_i,
   input  logic              v_i,
   output logic [DATA_W-1:0] result_o,
   output logic              wr_en_o,
   output logic              n_o,
   output logic              z_o,
   output logic              c_o,
   output logic              v_o
);

   localparam int LOG2W = $clog2(DATA_W);

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("cisa_reg_alu: DATA_W must be a power of two of at least 8");
      end
      if (AMT_W <= LOG2W || AMT_W > DATA_W) begin : g_bad_amt
         $error("cisa_reg_alu: AMT_W must exceed log2(DATA_W) and fit in DATA_W");
      end
      if (MUL_STYLE != 0 && MUL_STYLE != 1) begin : g_bad_mul
         $error("cisa_reg_alu: MUL_STYLE must be 0 or 1");
      end
   endgenerate

   alu_op_e           op;
   shift_kind_e       sh_kind;
   logic [DATA_W-1:0] logic_y, sh_res, sum, mul_p, add_a;
   logic              sh_c, add_sub, add_cin, add_c, add_v;
   alu_flags_t        fl_in, fl_out;

   assign op    = alu_op_e'(op_i);
   assign fl_in = '{n: n_i, z: z_i, c: c_i, v: v_i};

   always_comb begin
      unique case (op)
         OP_LSR:  sh_kind = SH_LSR;
         OP_ASR:  sh_kind = SH_ASR;
         OP_ROR:  sh_kind = SH_ROR;
         default: sh_kind = SH_LSL;
      endcase
      add_a   = (op == OP_NEG) ? '0 : dst_i;
      add_sub = (op == OP_SBC) || (op == OP_NEG) || (op == OP_CMP);
      unique case (op)
         OP_ADC, OP_SBC: add_cin = c_i;
         OP_NEG, OP_CMP: add_cin = 1'b1;
         default:        add_cin = 1'b0;
      endcase
   end

   cisa_alu_logic #(.DATA_W(DATA_W)) u_logic (
      .op (op), .a (dst_i), .b (src_i), .y (logic_y)
   );

   cisa_alu_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
      .kind (sh_kind), .val (dst_i), .amt (src_i[AMT_W-1:0]), .c_in (c_i),
      .res (sh_res), .c_out (sh_c)
   );

   cisa_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a (add_a), .b (src_i), .sub (add_sub), .cin (add_cin),
      .sum (sum), .c_out (add_c), .v_out (add_v)
   );

   cisa_alu_mul #(.DATA_W(DATA_W), .MUL_STYLE(MUL_STYLE)) u_mul (
      .a (dst_i), .b (src_i), .p (mul_p)
   );

   always_comb begin
      result_o = logic_y;
      wr_en_o  = 1'b1;
      fl_out   = fl_in;
      unique case (op)
         OP_LSL, OP_LSR, OP_ASR, OP_ROR: begin
            result_o = sh_res;
            fl_out.c = sh_c;
         end
         OP_ADC, OP_SBC, OP_NEG, OP_CMP, OP_CMN: begin
            result_o = sum;
            fl_out.c = add_c;
            fl_out.v = add_v;
         end
         OP_MUL:  result_o = mul_p;
         default: ;
      endcase
      if (op == OP_TST || op == OP_CMP || op == OP_CMN) wr_en_o = 1'b0;
      fl_out.n = result_o[DATA_W-1];
      fl_out.z = (result_o == '0);
   end

   assign n_o = fl_out.n;
   assign z_o = fl_out.z;
   assign c_o = fl_out.c;
   assign v_o = fl_out.v;

   always_comb begin
      if (op == OP_CMP || op == OP_CMN)
         AST_COMPARE_NO_WRITE: assert (!wr_en_o && z_o == (sum == '0)); // R5
      if (op == OP_NEG && src_i == '0)
         AST_NEG_ZERO_CARRY: assert (result_o == '0 && c_o && !v_o); // R4
      if (op == OP_AND || op == OP_EOR || op == OP_ORR || op == OP_BIC || op == OP_MVN || op == OP_TST)
         AST_LOGIC_KEEPS_CV: assert (c_o == c_i && v_o == v_i); // R2
      if (op == OP_MUL)
         AST_MUL_KEEPS_CV: assert (c_o == c_i && v_o == v_i); // R11
      if (op == OP_LSL && src_i[AMT_W-1:0] == '0)
         AST_ZERO_AMT_PASS: assert (result_o == dst_i && c_o == c_i); // R10
   end

endmodule

// File: tb/cisa_reg_alu_tb.sv
module cisa_reg_alu_tb;

   typedef struct {
      string       req;
      logic [31:0] res;
      logic        wr;
      logic [3:0]  fl;   // {n,z,c,v}
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  op_i = '0;
   logic [31:0] dst_i = '0, src_i = '0;
   logic        n_i = 1'b0, z_i = 1'b0, c_i = 1'b0, v_i = 1'b0;
   logic [31:0] result_o;
   logic        wr_en_o, n_o, z_o, c_o, v_o;

   int   total = 0;
   int   bad   = 0;
   bit   done  = 1'b0;
   exp_t q[$];
   logic [31:0] seed = 32'h1234_5679;

   always #2.5 clk = ~clk;   // 200 MHz

   cisa_reg_alu u_dut (
      .op_i (op_i), .dst_i (dst_i), .src_i (src_i),
      .n_i (n_i), .z_i (z_i), .c_i (c_i), .v_i (v_i),
      .result_o (result_o), .wr_en_o (wr_en_o),
      .n_o (n_o), .z_o (z_o), .c_o (c_o), .v_o (v_o)
   );

   function automatic void add_ref(input logic [31:0] a, input logic [31:0] b, input logic ci,
                                   output logic [31:0] r, output logic co, output logic vo);
      longint unsigned u;
      longint          s;
      u  = longint'({32'b0, a}) + longint'({32'b0, b}) + longint'(ci);
      s  = longint'($signed(a)) + longint'($signed(b)) + longint'(ci);
      r  = u[31:0];
      co = u[32];
      vo = (s > 64'sd2147483647) || (s < -64'sd2147483648);
   endfunction

   // bit-serial reference model built from the requirements
   function automatic exp_t model(input logic [3:0] op, input logic [31:0] d, input logic [31:0] s,
                                  input logic c, input logic v, input string req);
      exp_t        e;
      logic [31:0] r = d;
      logic        cn = c, vn = v;
      int          amt = int'(s[7:0]);
      e.wr = !(op == 4'd8 || op == 4'd10 || op == 4'd11);
      case (op)
         4'd0, 4'd8: r = d & s;
         4'd1:  r = d ^ s;
         4'd12: r = d | s;
         4'd14: r = d & ~s;
         4'd15: r = ~s;
         4'd2:  for (int i = 0; i < amt; i++) begin cn = r[31]; r = {r[30:0], 1'b0}; end
         4'd3:  for (int i = 0; i < amt; i++) begin cn = r[0]; r = {1'b0, r[31:1]}; end
         4'd4:  for (int i = 0; i < amt; i++) begin cn = r[0]; r = {r[31], r[31:1]}; end
         4'd7:  for (int i = 0; i < amt; i++) begin cn = r[0]; r = {r[0], r[31:1]}; end
         4'd5:  add_ref(d, s, c, r, cn, vn);
         4'd6:  add_ref(d, ~s, c, r, cn, vn);
         4'd9:  add_ref(32'd0, ~s, 1'b1, r, cn, vn);
         4'd10: add_ref(d, ~s, 1'b1, r, cn, vn);
         4'd11: add_ref(d, s, 1'b0, r, cn, vn);
         default: r = d * s;
      endcase
      e.res = r;
      e.fl  = {r[31], r == 32'd0, cn, vn};
      e.req = req;
      return e;
   endfunction

   task automatic send(input logic [3:0] op, input logic [31:0] d, input logic [31:0] s,
                       input logic [3:0] fl, input string req);
      @(posedge clk);
      #1;
      op_i = op; dst_i = d; src_i = s;
      {n_i, z_i, c_i, v_i} = fl;
      q.push_back(model(op, d, s, fl[1], fl[0], req));
   endtask

   function automatic logic [31:0] next_rand();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   // monitor: pops one expected item per cycle, half a period after drive
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         total++;
         if (wr_en_o !== e.wr || {n_o, z_o, c_o, v_o} !== e.fl || (e.wr && result_o !== e.res)) begin
            bad++;
            $display("FAIL %s: got res=%h wr=%b nzcv=%b, expected res=%h wr=%b nzcv=%b",
                     e.req, result_o, wr_en_o, {n_o, z_o, c_o, v_o}, e.res, e.wr, e.fl);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: got running, expected finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      rst = 1'b0;

      // R12: idle inputs after reset give zero with Z set
      send(4'd0, 32'd0, 32'd0, 4'b0000, "R12 reset");

      // R2 logic group, C and V preserved
      send(4'd14, 32'hF0F0_FFFF, 32'h0000_FF00, 4'b0011, "R2 BIC");
      send(4'd15, 32'h1234_5678, 32'h0000_0000, 4'b0001, "R2 MVN");
      send(4'd8,  32'hFFFF_0000, 32'h0000_FFFF, 4'b1011, "R2 TST");
      send(4'd1,  32'hAAAA_AAAA, 32'hAAAA_AAAA, 4'b0010, "R2 EOR");

      // R3 add / subtract with carry
      send(4'd5, 32'h7FFF_FFFF, 32'd0, 4'b0010, "R3 ADC overflow");
      send(4'd5, 32'hFFFF_FFFF, 32'd1, 4'b0000, "R3 ADC carry out");
      send(4'd6, 32'd5, 32'd3, 4'b0000, "R3 SBC borrow in");
      send(4'd6, 32'h8000_0000, 32'd1, 4'b0010, "R3 SBC overflow");

      // R4 negate
      send(4'd9, 32'hDEAD_BEEF, 32'd0, 4'b0000, "R4 NEG zero");
      send(4'd9, 32'd0, 32'd1, 4'b0010, "R4 NEG one");
      send(4'd9, 32'd0, 32'h8000_0000, 4'b0000, "R4 NEG min");

      // R5 compares
      send(4'd10, 32'd5, 32'd5, 4'b0000, "R5 CMP equal");
      send(4'd10, 32'd3, 32'd5, 4'b0010, "R5 CMP less");
      send(4'd11, 32'hFFFF_FFFF, 32'd1, 4'b0000, "R5 CMN");

      // R6 LSL
      send(4'd2, 32'h8000_0001, 32'd1,  4'b0000, "R6 LSL 1");
      send(4'd2, 32'h8000_0003, 32'd31, 4'b0000, "R6 LSL 31");
      send(4'd2, 32'h0000_0001, 32'd32, 4'b0000, "R6 LSL 32");
      send(4'd2, 32'hFFFF_FFFF, 32'd33, 4'b0010, "R6 LSL 33");

      // R7 LSR
      send(4'd3, 32'h8000_0001, 32'd1,  4'b0000, "R7 LSR 1");
      send(4'd3, 32'h8000_0000, 32'd32, 4'b0000, "R7 LSR 32");
      send(4'd3, 32'hFFFF_FFFF, 32'd33, 4'b0010, "R7 LSR 33");

      // R8 ASR
      send(4'd4, 32'h8000_0010, 32'd4,  4'b0000, "R8 ASR 4");
      send(4'd4, 32'h8000_0000, 32'd40, 4'b0000, "R8 ASR 40");
      send(4'd4, 32'h7FFF_FFFF, 32'd32, 4'b0010, "R8 ASR 32 positive");

      // R9 ROR
      send(4'd7, 32'h0000_000F, 32'd4,  4'b0000, "R9 ROR 4");
      send(4'd7, 32'h8000_0001, 32'd32, 4'b0000, "R9 ROR 32");
      send(4'd7, 32'h1234_5678, 32'd36, 4'b0000, "R9 ROR 36");

      // R10 amount from low byte only
      send(4'd2, 32'h1234_5678, 32'h0000_0100, 4'b0010, "R10 LSL zero amount");
      send(4'd3, 32'h1234_5678, 32'hFFFF_FF00, 4'b0010, "R10 LSR zero amount");
      send(4'd2, 32'h0000_0011, 32'hFFFF_FF04, 4'b0000, "R10 LSL upper bits");

      // R11 multiply
      send(4'd13, 32'h0001_0000, 32'h0001_0000, 4'b0011, "R11 MUL wrap");
      send(4'd13, 32'hFFFF_FFFF, 32'd3, 4'b0000, "R11 MUL negative");

      // R1 full sweep over every opcode with pseudo-random data
      for (int round = 0; round < 40; round++) begin
         for (int k = 0; k < 16; k++) begin
            logic [31:0] a, b;
            a = next_rand();
            b = next_rand();
            if (round % 4 == 0) b = {b[31:8], b[7:0] & 8'h3F};
            send(4'(k), a, b, 4'(next_rand()), "R1 sweep");
         end
      end

      repeat (4) @(posedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule